// File: doc/BRIEF.md
# Configurable Multi-Polynomial CRC Engine

A host-driven checksum engine. Through a small register port the host selects one of three polynomials (CRC-CCITT, CRC-16 or CRC-32) and sets four independent transform flags. It loads a starting value, then streams data words into a data register. Each data write is absorbed in a single clock cycle by an unrolled byte-serial update. Within a word, the most significant byte is taken first.

Reading the sum register returns the running value after the selected output bit-reversal and one's complement. In the two 16-bit modes only the low half carries the result. The mode and the raw running value can also be read back, so a host can save a computation and continue it later by writing that value into the seed register.

After reset the engine holds the CRC-CCITT setting with every flag clear and a running value of 0xFFFF. This computes the common "CCITT-FALSE" variant.

Top module: `crc_unit`

## Requirements
- R1: Mode bits [1:0] select the polynomial. 0 selects x^16+x^12+x^5+1 (0x1021), 1 selects x^16+x^15+x^2+1 (0x8005) and 2 selects the 32-bit polynomial 0x04C11DB7. All of them are processed MSB-first and without a final XOR, unless the flags request one.
- R2: Select value 3 behaves exactly as select value 2.
- R3: A write to address 1 (seed) loads all 32 bits of the running value on the next clock edge.
- R4: A write to address 2 folds data into the running value in one cycle. Size 0 uses bits [7:0], size 1 uses bits [15:0], and sizes 2 and 3 use bits [31:0]. The most significant byte of the used field goes first, and data bits outside the field are ignored. With write enable low nothing changes.
- R5: Mode bit 2 reverses the bit order inside every input byte before it is folded.
- R6: Mode bit 3 inverts every input bit before it is folded.
- R7: Mode bit 4 reverses the sum across the polynomial width: 16 bits in modes 0 and 1, 32 bits in modes 2 and 3.
- R8: Mode bit 5 inverts the sum across the polynomial width, after any output reversal.
- R9: In the 16-bit modes, sum bits [31:16] read as zero and every data write leaves running bits [31:16] at zero.
- R10: The read map is 0 = mode (bits [5:0], upper bits zero), 1 = raw running value, 2 = sum and 3 = zero. A write to address 0 takes bits [5:0] as the new mode. A write to address 3 changes nothing.
- R11: Reset sets the mode to 0 and the running value to 0xFFFF.
- R12: Writing back a saved mode and a saved running value resumes a computation, which then gives the same final sum as an unbroken run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_size | input | 2 | Data write size: 0 byte, 1 halfword, 2 or 3 word |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | DATA_W | Combinational read data |

## Verification
The bench runs standard catalogue check values over "123456789" and feeds the string as bytes, halfwords and words. An engine that takes bytes in the wrong order, or updates the wrong lanes for a given size, therefore misses the known results. Single-byte probes isolate each transform flag. Inverting the wrong bits, reversing across the wrong width, or reversing across the whole word instead of inside each byte each give a distinct wrong value.

Further probes cover a seed with upper bits set in a 16-bit mode, which would leak into the sum if the narrow path kept those bits, and a write to the spare address. A save-and-restore sequence exposes any hidden state that a seed write fails to replace.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;

   localparam int CRC_W  = 32;
   localparam int MODE_W = 6;
   localparam int ADDR_W = 2;

   typedef enum logic [1:0] {
      SEL_CCITT = 2'd0,
      SEL_C16   = 2'd1,
      SEL_C32   = 2'd2,
      SEL_C32B  = 2'd3
   } poly_sel_e;

   typedef struct packed {
      logic      cpl_out;
      logic      rev_out;
      logic      cpl_in;
      logic      rev_in;
      poly_sel_e sel;
   } mode_t;

   localparam mode_t MODE_DEFAULT = '0;

   localparam logic [ADDR_W-1:0] REG_MODE  = 2'd0;
   localparam logic [ADDR_W-1:0] REG_SEED  = 2'd1;
   localparam logic [ADDR_W-1:0] REG_DATA  = 2'd2;
   localparam logic [ADDR_W-1:0] REG_SPARE = 2'd3;

   localparam logic [31:0] POLY_32    = 32'h04C1_1DB7;
   localparam logic [15:0] POLY_CCITT = 16'h1021;
   localparam logic [15:0] POLY_C16   = 16'h8005;

   function automatic logic is_wide(input poly_sel_e s);
      return (s == SEL_C32) || (s == SEL_C32B);
   endfunction

   function automatic logic [15:0] narrow_poly(input poly_sel_e s);
      return (s == SEL_C16) ? POLY_C16 : POLY_CCITT;
   endfunction

   function automatic logic [7:0] flip8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   function automatic logic [15:0] flip16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   function automatic logic [31:0] flip32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // one byte, MSB first, through the selected LFSR
   function automatic logic [31:0] byte_step(input logic [31:0] c,
                                             input logic [7:0]  b,
                                             input poly_sel_e   s);
      logic [31:0] r;
      logic        fb;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (is_wide(s)) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0} ^ (fb ? POLY_32 : 32'h0);
         end else begin
            fb = r[15] ^ b[i];
            r  = {16'h0, r[14:0], 1'b0} ^ (fb ? {16'h0, narrow_poly(s)} : 32'h0);
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/crc_in_xform.sv
module crc_in_xform #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              rev_i,
   input  logic              cpl_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int NB = DATA_W / 8;

   for (genvar l = 0; l < NB; l++) begin : g_lane
      logic [7:0] raw, ordered;
      assign raw          = data_i[8*l +: 8];
      assign ordered      = rev_i ? crc_unit_pkg::flip8(raw) : raw;
      assign data_o[8*l +: 8] = cpl_i ? ~ordered : ordered;
   end
endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
   parameter int DATA_W = 32,
   parameter int NB     = DATA_W / 8,
   parameter int CNT_W  = $clog2(NB + 1)
) (
   input  logic [31:0]                  crc_i,
   input  logic [DATA_W-1:0]            data_i,
   input  logic [CNT_W-1:0]             nbytes_i,
   input  crc_unit_pkg::poly_sel_e      sel_i,
   output logic [31:0]                  crc_o
);
   localparam int SH_W = $clog2(DATA_W) + 1;

   logic [SH_W-1:0]   shamt;
   logic [DATA_W-1:0] aligned;

   // left-align the used field so stage 0 always sees the first byte
   assign shamt   = SH_W'((NB - int'(nbytes_i)) * 8);
   assign aligned = data_i << shamt;

   for (genvar s = 0; s < NB; s++) begin : g_stage
      logic [31:0] c_in, c_out;
      if (s == 0) begin : g_first
         assign c_in = crc_i;
      end else begin : g_next
         assign c_in = g_stage[s-1].c_out;
      end
      assign c_out = (CNT_W'(s) < nbytes_i)
                   ? crc_unit_pkg::byte_step(c_in, aligned[DATA_W-1-8*s -: 8], sel_i)
                   : c_in;
   end

   assign crc_o = g_stage[NB-1].c_out;
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform (
   input  logic [31:0]          run_i,
   input  crc_unit_pkg::mode_t  mode_i,
   output logic [31:0]          sum_o
);
   logic [15:0] n_ord, n_fin;
   logic [31:0] w_ord, w_fin;

   assign n_ord = mode_i.rev_out ? crc_unit_pkg::flip16(run_i[15:0]) : run_i[15:0];
   assign n_fin = mode_i.cpl_out ? ~n_ord : n_ord;
   assign w_ord = mode_i.rev_out ? crc_unit_pkg::flip32(run_i) : run_i;
   assign w_fin = mode_i.cpl_out ? ~w_ord : w_ord;

   assign sum_o = crc_unit_pkg::is_wide(mode_i.sel) ? w_fin : {16'h0, n_fin};
endmodule

// File: rtl/crc_unit.sv
module crc_unit #(
   parameter int          DATA_W     = 32,
   parameter logic [31:0] RESET_SEED = 32'h0000_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [1:0]        wr_size,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import crc_unit_pkg::*;

   localparam int NB    = DATA_W / 8;
   localparam int CNT_W = $clog2(NB + 1);

   if ((DATA_W % 8) != 0 || DATA_W < 32) begin : g_bad_width
      $error("crc_unit: DATA_W must be a multiple of 8 and at least 32");
   end

   mode_t             mode_q;
   logic [31:0]       run_q;
   logic [DATA_W-1:0] din_x;
   logic [CNT_W-1:0]  nbytes;
   logic [31:0]       fold_w;
   logic [31:0]       sum_w;

   always_comb begin
      case (wr_size)
         2'd0:    nbytes = CNT_W'(1);
         2'd1:    nbytes = CNT_W'(2);
         default: nbytes = CNT_W'(4);
      endcase
   end

   crc_in_xform #(.DATA_W(DATA_W)) u_in (
      .data_i (wr_data),
      .rev_i  (mode_q.rev_in),
      .cpl_i  (mode_q.cpl_in),
      .data_o (din_x)
   );

   crc_fold #(.DATA_W(DATA_W)) u_fold (
      .crc_i    (run_q),
      .data_i   (din_x),
      .nbytes_i (nbytes),
      .sel_i    (mode_q.sel),
      .crc_o    (fold_w)
   );

   crc_out_xform u_out (
      .run_i  (run_q),
      .mode_i (mode_q),
      .sum_o  (sum_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_DEFAULT;
         run_q  <= RESET_SEED;
      end else if (wr_en) begin
         case (wr_addr)
            REG_MODE: mode_q <= mode_t'(wr_data[MODE_W-1:0]);
            REG_SEED: run_q  <= wr_data[31:0];
            REG_DATA: run_q  <= fold_w;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         2'd0:    rd_data = DATA_W'(mode_q);
         2'd1:    rd_data = DATA_W'(run_q);
         2'd2:    rd_data = DATA_W'(sum_w);
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [5:0]        mode_q,
   input logic [31:0]       run_q,
   input logic [31:0]       sum_w
);
   logic narrow;
   assign narrow = (mode_q[1:0] == 2'd0) || (mode_q[1:0] == 2'd1);

   assert_seed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1) |=> (run_q == $past(wr_data[31:0])));

   assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> (mode_q == $past(wr_data[5:0])));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr == 2'd3) |=> ($stable(run_q) && $stable(mode_q)));

   assert_narrow_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |-> (sum_w[31:16] == 16'h0));

   assert_narrow_fold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && narrow) |=> (run_q[31:16] == 16'h0));

   assert_reset_state_R11: assert property (@(posedge clk)
      $rose(rst_n) |-> (run_q == 32'h0000_FFFF && mode_q == 6'h0));
endmodule

bind crc_unit crc_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .mode_q  (mode_q),
   .run_q   (run_q),
   .sum_w   (sum_w)
);

// File: tb/sim_crc_unit.sv
`timescale 1ns/1ps
module sim_crc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [1:0]  wr_size = 2'd0;
   logic [31:0] wr_data = 32'h0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   crc_unit u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                .wr_size(wr_size), .wr_data(wr_data), .rd_addr(rd_addr),
                .rd_data(rd_data));

   // mode[71:66] seed[65:34] pattern[33:32] expected[31:0]
   localparam logic [71:0] VEC [10] = '{
      {6'h00, 32'h0000FFFF, 2'd0, 32'h000029B1},  // R1 ccitt-false bytes
      {6'h00, 32'h0000FFFF, 2'd1, 32'h000029B1},  // R4 halfwords
      {6'h00, 32'h00000000, 2'd2, 32'h000031C3},  // R1 R4 words
      {6'h14, 32'h00000000, 2'd0, 32'h00002189},  // R5 R7 16-bit reflected
      {6'h01, 32'h00000000, 2'd2, 32'h0000FEE8},  // R1 crc-16 plain
      {6'h15, 32'h00000000, 2'd1, 32'h0000BB3D},  // R1 crc-16 reflected
      {6'h36, 32'hFFFFFFFF, 2'd2, 32'hCBF43926},  // R1 R8 crc-32
      {6'h22, 32'hFFFFFFFF, 2'd0, 32'hFC891918},  // R8 crc-32 msb-first
      {6'h02, 32'hFFFFFFFF, 2'd1, 32'h0376E6E7},  // R1 no transforms
      {6'h37, 32'hFFFFFFFF, 2'd0, 32'hCBF43926}   // R2 select 3
   };

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [1:0] sz);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = sz;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic feed(input logic [1:0] pat);
      if (pat == 2'd0) begin
         for (int i = 0; i < 9; i++) wr(2'd2, 32'h31 + 32'(i), 2'd0);
      end else if (pat == 2'd1) begin
         wr(2'd2, 32'h3132, 2'd1); wr(2'd2, 32'h3334, 2'd1);
         wr(2'd2, 32'h3536, 2'd1); wr(2'd2, 32'h3738, 2'd1);
         wr(2'd2, 32'h39, 2'd0);
      end else begin
         wr(2'd2, 32'h31323334, 2'd2); wr(2'd2, 32'h35363738, 2'd3);
         wr(2'd2, 32'h39, 2'd0);
      end
   endtask

   initial begin
      #100000;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, saved;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); check("R11 mode after reset", v, 32'h0);
      rd(2'd1, v); check("R11 running after reset", v, 32'h0000FFFF);
      rd(2'd2, v); check("R10 sum after reset", v, 32'h0000FFFF);
      rd(2'd3, v); check("R10 spare reads zero", v, 32'h0);

      for (int k = 0; k < 10; k++) begin
         wr(2'd0, {26'h0, VEC[k][71:66]}, 2'd0);
         wr(2'd1, VEC[k][65:34], 2'd0);
         feed(VEC[k][33:32]);
         rd(2'd2, v);
         check($sformatf("R1 R4 vector %0d", k), v, VEC[k][31:0]);
      end

      // R6 complement input: 0x00 becomes 0xFF
      wr(2'd0, 32'h08, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h00, 2'd0);
      rd(2'd1, v); check("R6 input complement", v, 32'h00001EF0);

      // R5 byte reverse: 0x80 becomes 0x01
      wr(2'd0, 32'h04, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h80, 2'd0);
      rd(2'd1, v); check("R5 input byte reverse", v, 32'h00001021);
      wr(2'd0, 32'h10, 2'd0);
      rd(2'd2, v); check("R7 16-bit output reverse", v, 32'h00008408);
      wr(2'd0, 32'h20, 2'd0);
      rd(2'd2, v); check("R8 16-bit output complement", v, 32'h0000EFDE);
      wr(2'd0, 32'h30, 2'd0);
      rd(2'd2, v); check("R8 reverse then complement", v, 32'h00007BF7);

      // R7 32-bit reverse width
      wr(2'd0, 32'h12, 2'd0); wr(2'd1, 32'h1, 2'd0);
      rd(2'd2, v); check("R7 32-bit output reverse", v, 32'h80000000);

      // R10 mode field width and spare write
      wr(2'd0, 32'hFFFFFFC7, 2'd0);
      rd(2'd0, v); check("R10 mode readback", v, 32'h07);
      wr(2'd3, 32'h12345678, 2'd2);
      rd(2'd1, v); check("R10 spare write leaves running", v, 32'h1);
      rd(2'd0, v); check("R10 spare write leaves mode", v, 32'h07);

      // R4 disabled write has no effect
      @(negedge clk); wr_addr = 2'd2; wr_data = 32'hDEADBEEF; wr_size = 2'd2;
      @(negedge clk);
      rd(2'd1, v); check("R4 no write without enable", v, 32'h1);

      // R9 narrow mode ignores upper seed bits in the sum
      wr(2'd0, 32'h0, 2'd0); wr(2'd1, 32'hABCD0000, 2'd0);
      rd(2'd1, v); check("R3 full seed load", v, 32'hABCD0000);
      rd(2'd2, v); check("R9 narrow sum upper zero", v, 32'h0);
      wr(2'd2, 32'hFFFFFF01, 2'd0);
      rd(2'd1, v); check("R9 R4 narrow fold clears upper", v, 32'h00001021);

      // R12 save and resume
      wr(2'd0, 32'h36, 2'd0); wr(2'd1, 32'hFFFFFFFF, 2'd0);
      wr(2'd2, 32'h31323334, 2'd2);
      rd(2'd1, saved);
      wr(2'd0, 32'h01, 2'd0); wr(2'd1, 32'h5555AAAA, 2'd0);
      wr(2'd2, 32'h77, 2'd0);
      wr(2'd0, 32'h36, 2'd0); wr(2'd1, saved, 2'd0);
      wr(2'd2, 32'h35363738, 2'd2); wr(2'd2, 32'h39, 2'd0);
      rd(2'd2, v); check("R12 resumed result", v, 32'hCBF43926);

      // R11 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(2'd1, v); check("R11 running after second reset", v, 32'h0000FFFF);
      rd(2'd0, v); check("R11 mode after second reset", v, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule